// File: doc/BRIEF.md
# Configuration Source Sequencer

This block sequences how a reprogrammable logic device loads its configuration after power comes up. It first waits for the supplies to be reported good. It then waits for the external active-low configuration reset pin to be released. After that it takes one look at the slave-select pin and at a flag that reports whether the on-chip nonvolatile configuration store holds an image.

From that single sample it picks one of three sources. A low slave-select means the device waits for an external controller to push the image in as an SPI slave. A high slave-select with a programmed store means the device loads from the internal nonvolatile memory. A high slave-select with an empty store means the device reads an external flash as SPI master. Each loader is represented only by a one-cycle start strobe and a done/error input pair, so the bitstream format and the serial datapath are not part of this block.

When the chosen loader reports success, the sequencer raises its done output and pulses a global reset to the fabric flip-flops for a set number of cycles. A low pulse on the reset pin restarts the whole sequence, but only if the pulse lasts at least a minimum time (250 ns by default, converted to clock cycles from a clock-period parameter). Shorter pulses are ignored. A loader error sends the sequencer back to the reset-wait state with done low, and it stays there until a qualifying reset pulse arrives.

Top module: `cfg_src_seq`

## Requirements
- R1: While the asynchronous reset `arst_n` is low, and right after it is released, `state_dbg` reads 0 (power wait). At that point `cfg_done`, `glob_rst`, `nvm_start`, `flash_start` and `slave_arm` are all 0.
- R2: While `por_ok` is low, the state stays 0 and `cfg_done` stays 0. Dropping `por_ok` in any state gives state 0 one cycle later and clears any pending need for a restart pulse. When `por_ok` rises in state 0, the next cycle is state 1 (reset wait).
- R3: In state 1, a low `cfg_rst_pin_n` keeps the sequencer waiting. Three cycles after the pin goes high (two synchronizer stages plus one), the state is 2 (source pick). State 2 is only ever entered from state 1.
- R4: In state 2, a synchronized `sel_pin_n` of 0 leads to state 5 (slave wait) on the next cycle, whatever `nvm_programmed` holds. `slave_arm` is high for exactly that one cycle.
- R5: In state 2, `sel_pin_n` = 1 with `nvm_programmed` = 1 leads to state 3 (internal load), with `nvm_start` high for exactly one cycle. At most one start strobe is ever high.
- R6: In state 2, `sel_pin_n` = 1 with `nvm_programmed` = 0 leads to state 4 (flash master load), with `flash_start` high for exactly one cycle.
- R7: `sel_pin_n` is sampled only in state 2. Changing it while a load is in progress does not change the state.
- R8: When the active loader's done input is high, the next cycle is state 6 (ready) with `cfg_done` = 1. `cfg_done` is 0 in every other state, and it only rises after a loader done input.
- R9: `glob_rst` goes high in the same cycle that `cfg_done` rises and stays high for exactly `GRST_CYC` cycles (default 4).
- R10: When the active loader's error input is high (and done is low), the next cycle is state 1 with `cfg_done` = 0. The sequencer then stays in state 1 even with the pin high, until a qualifying restart pulse arrives.
- R11: A qualifying pulse is one where `cfg_rst_pin_n` is low for at least PULSE_CYC = ceil(MIN_PULSE_NS·1000 / CLK_PERIOD_PS) cycles (25 by default). In any state other than 0, such a pulse returns the state to 1 with `cfg_done` = 0, and the state is 2 three cycles after the pin rises again.
- R12: A low pulse shorter than PULSE_CYC cycles has no effect. A ready sequencer stays in state 6 with `cfg_done` = 1, and a sequencer blocked by an error stays in state 1.
- R13: Done inputs from loaders other than the one selected are ignored, and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| por_ok | input | 1 | High when all supplies are in range |
| cfg_rst_pin_n | input | 1 | Configuration reset pin, active low, asynchronous to clk |
| sel_pin_n | input | 1 | Slave-select pin, asynchronous to clk |
| nvm_programmed | input | 1 | High when the nonvolatile store holds an image |
| nvm_start | output | 1 | One-cycle start strobe to the internal-memory loader |
| nvm_done | input | 1 | Internal-memory loader finished successfully |
| nvm_err | input | 1 | Internal-memory loader failed |
| flash_start | output | 1 | One-cycle start strobe to the flash master loader |
| flash_done | input | 1 | Flash master loader finished successfully |
| flash_err | input | 1 | Flash master loader failed |
| slave_arm | output | 1 | One-cycle strobe enabling the slave receiver |
| slave_done | input | 1 | Slave receive finished successfully |
| slave_err | input | 1 | Slave receive failed |
| cfg_done | output | 1 | Configuration complete |
| glob_rst | output | 1 | Global reset pulse to the fabric after completion |
| state_dbg | output | 3 | Current state code (0 to 6) |

## Verification
The timing of each result depends on where the stimulus enters the block:
- Changes on `por_ok`, `nvm_programmed` and the loader inputs reach the state one clock edge later.
- Changes on the two pins pass through the synchronizer first. A rising reset pin shows up as state 2 at the third edge.
- A falling reset pin qualifies as a restart at edge PULSE_CYC+2 of the low period.
- The start strobes appear at the edge that leaves state 2.
- `glob_rst` turns on at the same edge as `cfg_done` and turns off GRST_CYC edges later.

The bench drives every input on the falling clock edge and advances a counted number of rising edges before each sample. That count is always the one listed above. Each check therefore lands in the first cycle where the result is due, and the checks of a held state are repeated a few cycles later.

// File: rtl/cfg_src_pkg.sv
package cfg_src_pkg;

   typedef enum logic [2:0] {
      ST_POWER = 3'd0,
      ST_HOLD  = 3'd1,
      ST_PICK  = 3'd2,
      ST_NVM   = 3'd3,
      ST_FLASH = 3'd4,
      ST_SLAVE = 3'd5,
      ST_READY = 3'd6
   } cfg_state_e;

   localparam int NUM_SRC   = 3;
   localparam int IDX_NVM   = 0;
   localparam int IDX_FLASH = 1;
   localparam int IDX_SLAVE = 2;

   // Load state that belongs to a loader index
   function automatic cfg_state_e load_state_of(input int idx);
      case (idx)
         IDX_NVM:   return ST_NVM;
         IDX_FLASH: return ST_FLASH;
         default:   return ST_SLAVE;
      endcase
   endfunction

   // Round a duration up to whole clock cycles
   function automatic int cycles_for_ns(input int ns, input int period_ps);
      return (ns * 1000 + period_ps - 1) / period_ps;
   endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cfg_pulse_qual.sv
module cfg_pulse_qual #(
   parameter int MIN_CYC = 25
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_low,
   output logic hit
);

   generate
      if (MIN_CYC < 1) begin : g_bad_min
         $error("cfg_pulse_qual: MIN_CYC must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0] FULL = CW'(MIN_CYC);
   localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

   logic [CW-1:0] low_cnt;

   // Counts consecutive low cycles and saturates, so one pulse gives one hit
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         low_cnt <= '0;
      end else if (!pin_low) begin
         low_cnt <= '0;
      end else if (low_cnt != FULL) begin
         low_cnt <= low_cnt + CW'(1);
      end
   end

   assign hit = pin_low && (low_cnt == LAST);

endmodule

// File: rtl/cfg_grst_gen.sv
module cfg_grst_gen #(
   parameter int HOLD_CYC = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic fire,
   output logic grst
);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("cfg_grst_gen: HOLD_CYC must be at least 1");
      end else if (HOLD_CYC == 1) begin : g_single
         logic grst_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) grst_q <= 1'b0;
            else         grst_q <= fire;
         end
         assign grst = grst_q;
      end else begin : g_stretch
         localparam int CW = $clog2(HOLD_CYC + 1);
         logic [CW-1:0] left;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               left <= '0;
            end else if (fire) begin
               left <= CW'(HOLD_CYC);
            end else if (left != '0) begin
               left <= left - CW'(1);
            end
         end
         assign grst = (left != '0);
      end
   endgenerate

endmodule

// File: rtl/cfg_src_fsm.sv
module cfg_src_fsm
   import cfg_src_pkg::*;
(
   input  logic               clk,
   input  logic               arst_n,
   input  logic               por_ok,
   input  logic               pin_high,
   input  logic               sel_high,
   input  logic               nvm_prog,
   input  logic               restart,
   input  logic [NUM_SRC-1:0] ldr_done,
   input  logic [NUM_SRC-1:0] ldr_err,
   output cfg_state_e         state,
   output logic [NUM_SRC-1:0] start,
   output logic               enter_ready
);

   cfg_state_e         nxt;
   logic               need_q, need_nxt;
   logic [NUM_SRC-1:0] start_nxt;
   logic [NUM_SRC-1:0] hit_done, hit_err;
   logic               act_done, act_err;

   // Only the loader that owns the current state is listened to
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign hit_done[g] = (state == load_state_of(g)) && ldr_done[g];
      assign hit_err[g]  = (state == load_state_of(g)) && ldr_err[g];
   end

   assign act_done = |hit_done;
   assign act_err  = |hit_err;

   always_comb begin
      nxt         = state;
      need_nxt    = need_q;
      start_nxt   = '0;
      enter_ready = 1'b0;
      if (!por_ok) begin
         nxt      = ST_POWER;
         need_nxt = 1'b0;
      end else if (restart && (state != ST_POWER)) begin
         nxt      = ST_HOLD;
         need_nxt = 1'b0;
      end else begin
         case (state)
            ST_POWER: nxt = ST_HOLD;
            ST_HOLD: begin
               if (pin_high && !need_q) nxt = ST_PICK;
            end
            ST_PICK: begin
               if (!sel_high) begin
                  nxt                  = ST_SLAVE;
                  start_nxt[IDX_SLAVE] = 1'b1;
               end else if (nvm_prog) begin
                  nxt                  = ST_NVM;
                  start_nxt[IDX_NVM]   = 1'b1;
               end else begin
                  nxt                  = ST_FLASH;
                  start_nxt[IDX_FLASH] = 1'b1;
               end
            end
            ST_NVM, ST_FLASH, ST_SLAVE: begin
               if (act_done) begin
                  nxt         = ST_READY;
                  enter_ready = 1'b1;
               end else if (act_err) begin
                  nxt      = ST_HOLD;
                  need_nxt = 1'b1;
               end
            end
            ST_READY: nxt = ST_READY;
            default:  nxt = ST_POWER;
         endcase
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state  <= ST_POWER;
         need_q <= 1'b0;
         start  <= '0;
      end else begin
         state  <= nxt;
         need_q <= need_nxt;
         start  <= start_nxt;
      end
   end

endmodule

// File: rtl/cfg_src_seq.sv
module cfg_src_seq
   import cfg_src_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 10000,
   parameter int MIN_PULSE_NS  = 250,
   parameter int SYNC_STAGES   = 2,
   parameter int GRST_CYC      = 4
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       por_ok,
   input  logic       cfg_rst_pin_n,
   input  logic       sel_pin_n,
   input  logic       nvm_programmed,
   output logic       nvm_start,
   input  logic       nvm_done,
   input  logic       nvm_err,
   output logic       flash_start,
   input  logic       flash_done,
   input  logic       flash_err,
   output logic       slave_arm,
   input  logic       slave_done,
   input  logic       slave_err,
   output logic       cfg_done,
   output logic       glob_rst,
   output logic [2:0] state_dbg
);

   localparam int PULSE_CYC = cycles_for_ns(MIN_PULSE_NS, CLK_PERIOD_PS);

   generate
      if (CLK_PERIOD_PS < 1) begin : g_bad_period
         $error("cfg_src_seq: CLK_PERIOD_PS must be positive");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("cfg_src_seq: minimum pulse must span at least one cycle");
      end
   endgenerate

   logic               pin_s, sel_s, restart, enter_ready;
   logic [NUM_SRC-1:0] ldr_done, ldr_err, start;
   cfg_state_e         state;

   // Reset pin resets to low so nothing proceeds before the pin is seen
   cfg_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pin_sync (
      .clk(clk), .arst_n(arst_n), .d(cfg_rst_pin_n), .q(pin_s)
   );

   cfg_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sel_sync (
      .clk(clk), .arst_n(arst_n), .d(sel_pin_n), .q(sel_s)
   );

   cfg_pulse_qual #(.MIN_CYC(PULSE_CYC)) i_pulse_qual (
      .clk(clk), .arst_n(arst_n), .pin_low(!pin_s), .hit(restart)
   );

   assign ldr_done[IDX_NVM]   = nvm_done;
   assign ldr_done[IDX_FLASH] = flash_done;
   assign ldr_done[IDX_SLAVE] = slave_done;
   assign ldr_err[IDX_NVM]    = nvm_err;
   assign ldr_err[IDX_FLASH]  = flash_err;
   assign ldr_err[IDX_SLAVE]  = slave_err;

   cfg_src_fsm i_fsm (
      .clk(clk), .arst_n(arst_n), .por_ok(por_ok),
      .pin_high(pin_s), .sel_high(sel_s), .nvm_prog(nvm_programmed),
      .restart(restart), .ldr_done(ldr_done), .ldr_err(ldr_err),
      .state(state), .start(start), .enter_ready(enter_ready)
   );

   cfg_grst_gen #(.HOLD_CYC(GRST_CYC)) i_grst (
      .clk(clk), .arst_n(arst_n), .fire(enter_ready), .grst(glob_rst)
   );

   assign nvm_start   = start[IDX_NVM];
   assign flash_start = start[IDX_FLASH];
   assign slave_arm   = start[IDX_SLAVE];
   assign cfg_done    = (state == ST_READY);
   assign state_dbg   = state;

endmodule

// File: rtl/cfg_src_seq_chk.sv
module cfg_src_seq_chk (
   input logic       clk,
   input logic       arst_n,
   input logic       por_ok,
   input logic       nvm_start,
   input logic       nvm_done,
   input logic       nvm_err,
   input logic       flash_start,
   input logic       flash_done,
   input logic       slave_arm,
   input logic       slave_done,
   input logic       cfg_done,
   input logic       glob_rst,
   input logic [2:0] state_dbg
);

   AST_POR_FORCES_POWER: assert property (@(posedge clk) disable iff (!arst_n)
      !por_ok |=> (state_dbg == 3'd0) && !cfg_done); // R2

   AST_PICK_FROM_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
      (state_dbg == 3'd2 && $past(state_dbg) != 3'd2) |-> $past(state_dbg) == 3'd1); // R3

   AST_ONE_START: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0({nvm_start, flash_start, slave_arm})); // R5

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
      (nvm_start || flash_start || slave_arm) |=> !(nvm_start || flash_start || slave_arm)); // R4

   AST_DONE_NEEDS_LOADER: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(cfg_done) |-> $past(nvm_done || flash_done || slave_done)); // R8

   AST_GRST_WITH_DONE: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(cfg_done) |-> glob_rst); // R9

   AST_ERR_TO_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
      (state_dbg == 3'd3 && nvm_err && !nvm_done && por_ok) |=> (state_dbg == 3'd1) && !cfg_done); // R10

endmodule

bind cfg_src_seq cfg_src_seq_chk i_cfg_src_seq_chk (
   .clk(clk), .arst_n(arst_n), .por_ok(por_ok),
   .nvm_start(nvm_start), .nvm_done(nvm_done), .nvm_err(nvm_err),
   .flash_start(flash_start), .flash_done(flash_done),
   .slave_arm(slave_arm), .slave_done(slave_done),
   .cfg_done(cfg_done), .glob_rst(glob_rst), .state_dbg(state_dbg)
);

// File: tb/test_cfg_src_seq.sv
module test_cfg_src_seq;

   localparam int PULSE = 25;   // ceil(250 ns / 10 ns)
   localparam int GRST  = 4;

   logic clk = 1'b0;
   logic arst_n, por_ok, cfg_rst_pin_n, sel_pin_n, nvm_programmed;
   logic nvm_done, nvm_err, flash_done, flash_err, slave_done, slave_err;
   logic nvm_start, flash_start, slave_arm, cfg_done, glob_rst;
   logic [2:0] state_dbg;

   int total = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   cfg_src_seq i_cfg_src_seq (
      .clk(clk), .arst_n(arst_n), .por_ok(por_ok),
      .cfg_rst_pin_n(cfg_rst_pin_n), .sel_pin_n(sel_pin_n),
      .nvm_programmed(nvm_programmed),
      .nvm_start(nvm_start), .nvm_done(nvm_done), .nvm_err(nvm_err),
      .flash_start(flash_start), .flash_done(flash_done), .flash_err(flash_err),
      .slave_arm(slave_arm), .slave_done(slave_done), .slave_err(slave_err),
      .cfg_done(cfg_done), .glob_rst(glob_rst), .state_dbg(state_dbg)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Loader index: 0 internal memory, 1 flash master, 2 slave
   function automatic int exp_idx(input bit sel, input bit prog);
      if (!sel) return 2;
      return prog ? 0 : 1;
   endfunction

   function automatic int exp_state(input int idx);
      return 3 + idx;
   endfunction

   function automatic string req_of(input int idx);
      case (idx)
         0: return "R5";
         1: return "R6";
         default: return "R4";
      endcase
   endfunction

   task automatic set_ld(input int idx, input bit d, input bit e);
      case (idx)
         0: begin nvm_done = d; nvm_err = e; end
         1: begin flash_done = d; flash_err = e; end
         default: begin slave_done = d; slave_err = e; end
      endcase
   endtask

   // Entered with state 2 just observed; pins already set up
   task automatic run_load(input bit sel, input bit prog, input bit ok);
      int idx = exp_idx(sel, prog);
      int st  = exp_state(idx);
      int other;
      tick(1);
      chk(req_of(idx), "load state", int'(state_dbg), st);
      chk(req_of(idx), "start strobes", int'({slave_arm, flash_start, nvm_start}), 1 << idx);
      tick(1);
      chk(req_of(idx), "strobe width", int'({slave_arm, flash_start, nvm_start}), 0);
      sel_pin_n = ~sel;
      tick(3);
      chk("R7", "state after select change", int'(state_dbg), st);
      other = (idx + 1 + int'($urandom % 2)) % 3;
      set_ld(other, 1'b1, 1'b0);
      tick(1);
      set_ld(other, 1'b0, 1'b0);
      chk("R13", "foreign done ignored", int'(state_dbg), st);
      chk("R13", "done stays low", int'(cfg_done), 0);
      if (ok) begin
         set_ld(idx, 1'b1, 1'b0);
         tick(1);
         set_ld(idx, 1'b0, 1'b0);
         chk("R8", "ready state", int'(state_dbg), 6);
         chk("R8", "cfg_done", int'(cfg_done), 1);
         chk("R9", "glob_rst first cycle", int'(glob_rst), 1);
         tick(GRST - 1);
         chk("R9", "glob_rst last cycle", int'(glob_rst), 1);
         tick(1);
         chk("R9", "glob_rst ended", int'(glob_rst), 0);
      end else begin
         set_ld(idx, 1'b0, 1'b1);
         tick(1);
         set_ld(idx, 1'b0, 1'b0);
         chk("R10", "error state", int'(state_dbg), 1);
         chk("R10", "done after error", int'(cfg_done), 0);
         tick(6);
         chk("R10", "blocked with pin high", int'(state_dbg), 1);
      end
   endtask

   task automatic trial(input bit sel, input bit prog, input bit ok, input bit short_first);
      int prev_st = int'(state_dbg);
      int prev_dn = int'(cfg_done);
      int len;
      if (short_first) begin
         len = 1 + int'($urandom % (PULSE - 1));
         cfg_rst_pin_n = 1'b0;
         tick(len);
         cfg_rst_pin_n = 1'b1;
         tick(5);
         chk("R12", "state after short pulse", int'(state_dbg), prev_st);
         chk("R12", "done after short pulse", int'(cfg_done), prev_dn);
      end
      sel_pin_n      = sel;
      nvm_programmed = prog;
      len = PULSE + int'($urandom % 4);
      cfg_rst_pin_n = 1'b0;
      tick(len);
      cfg_rst_pin_n = 1'b1;
      tick(2);
      chk("R11", "restart state", int'(state_dbg), 1);
      chk("R11", "done cleared", int'(cfg_done), 0);
      tick(1);
      chk("R11", "pick after release", int'(state_dbg), 2);
      run_load(sel, prog, ok);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      arst_n = 1'b0; por_ok = 1'b0; cfg_rst_pin_n = 1'b0;
      sel_pin_n = 1'b1; nvm_programmed = 1'b0;
      nvm_done = 1'b0; nvm_err = 1'b0; flash_done = 1'b0;
      flash_err = 1'b0; slave_done = 1'b0; slave_err = 1'b0;
      tick(3);
      chk("R1", "reset state", int'(state_dbg), 0);
      chk("R1", "reset outputs", int'({cfg_done, glob_rst, nvm_start, flash_start, slave_arm}), 0);
      arst_n = 1'b1;
      tick(5);
      chk("R2", "waits for supplies", int'(state_dbg), 0);
      chk("R1", "outputs after release", int'({cfg_done, glob_rst, nvm_start, flash_start, slave_arm}), 0);
      por_ok = 1'b1;
      tick(1);
      chk("R2", "reset wait after supplies", int'(state_dbg), 1);
      tick(8);
      chk("R3", "pin low delays start", int'(state_dbg), 1);
      sel_pin_n = 1'b1; nvm_programmed = 1'b1;
      cfg_rst_pin_n = 1'b1;
      tick(2);
      chk("R3", "still waiting during sync", int'(state_dbg), 1);
      tick(1);
      chk("R3", "pick three cycles after pin", int'(state_dbg), 2);
      run_load(1'b1, 1'b1, 1'b1);

      // Directed corners: slave with programmed store, error, flash path
      trial(1'b0, 1'b1, 1'b0, 1'b1);
      trial(1'b1, 1'b0, 1'b1, 1'b0);
      trial(1'b0, 1'b0, 1'b1, 1'b1);
      trial(1'b1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 30; i++) begin
         trial(1'($urandom % 2), 1'($urandom % 2), ($urandom % 4) != 0, 1'($urandom % 2));
      end

      // Supply drop from a settled state
      por_ok = 1'b0;
      sel_pin_n = 1'b1; nvm_programmed = 1'b0;
      tick(1);
      chk("R2", "supply drop state", int'(state_dbg), 0);
      chk("R2", "supply drop done", int'(cfg_done), 0);
      tick(3);
      chk("R2", "stays in power wait", int'(state_dbg), 0);
      por_ok = 1'b1;
      tick(1);
      chk("R2", "reset wait after return", int'(state_dbg), 1);
      tick(1);
      chk("R2", "no restart pulse needed", int'(state_dbg), 2);
      run_load(1'b1, 1'b0, 1'b1);

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule